// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block sits between a memory-mapped read port and a serial shifter that drives the flash pins. A read request carries only an address. The block expands each accepted request into an ordered run of micro-operations for the shifter: an optional opcode byte, a configurable number of address bytes, an optional dummy stretch and one receive frame. It then sends a micro-operation that releases chip select. The received frame is handed back on a valid/ready response port.

A set of static template inputs shapes every read. The template holds the opcode and whether it is sent, how many address bytes go out, the code driven at the start of the dummy stretch and the length of that stretch, and a lane mode for each phase. Lane mode values are 0 for one lane, 1 for two lanes and 2 for four lanes. The template must stay steady while a read is in flight. A lock output tells the shifter-side arbiter to keep this requester selected from acceptance until chip select is released. No new request is taken until the previous response has been consumed.

Top module: `flash_read_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `uop_valid`, `lock` and `resp_valid` are low.
- R2: `req_ready` is high exactly when `en` is high, no read is in flight and no response is waiting. After an accepted request, `req_ready` is low in the next cycle.
- R3: When `cmd_en` is 1, the first micro-op of a read is a transmit (`uop_rx`=0, `uop_release`=0) carrying `cmd_code` with `uop_cnt`=8 and `uop_proto`=`cmd_proto`. When `cmd_en` is 0, no opcode micro-op is sent. A micro-op's fields stay stable while it waits for `uop_ready`.
- R4: Address micro-ops follow as transmits with `uop_cnt`=8 and `uop_proto`=`addr_proto`. Their count is `addr_bytes` clamped to 4. They carry the low bytes of the request address, most significant of those first. A count of 0 sends no address micro-op.
- R5: When `pad_cycles` is non-zero, one transmit micro-op follows with `uop_data`=`pad_code`, `uop_cnt`=`pad_cycles` and `uop_proto`=`addr_proto`. When `pad_cycles` is zero, this micro-op is skipped.
- R6: Next comes one receive micro-op (`uop_rx`=1, `uop_data`=0, `uop_cnt`=8, `uop_proto`=`data_proto`). The block then waits for `rx_valid` and captures `rx_data`. `rx_valid` has no effect at any other time.
- R7: After the capture, a release micro-op is sent with `uop_release`=1 and every other field zero.
- R8: `lock` is high from the cycle after acceptance until the release micro-op's handshake, and low otherwise.
- R9: After the release handshake, `resp_valid` is high with the captured frame on `resp_data`. Both are held until `resp_ready` is seen.
- R10: While `en` is low, `uop_valid` and `req_ready` are low. A read in progress resumes where it stopped once `en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Permits accepting and issuing |
| cmd_en | input | 1 | Send the opcode byte |
| cmd_code | input | 8 | Opcode byte |
| cmd_proto | input | 2 | Lane mode of the opcode |
| addr_bytes | input | ABW | Address byte count (clamped to ADDR_BYTES) |
| addr_proto | input | 2 | Lane mode of the address and dummy stretch |
| pad_code | input | 8 | Code driven at the start of the dummy stretch |
| pad_cycles | input | CNT_W | Length of the dummy stretch in cycles |
| data_proto | input | 2 | Lane mode of the receive frame |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Read request taken |
| req_addr | input | AW | Read address |
| uop_valid | output | 1 | Micro-op offered to the shifter |
| uop_ready | input | 1 | Shifter takes the micro-op |
| uop_data | output | 8 | Byte to transmit |
| uop_cnt | output | CNT_W | Bits or cycles for the micro-op |
| uop_proto | output | 2 | Lane mode for the micro-op |
| uop_rx | output | 1 | Micro-op receives a frame |
| uop_release | output | 1 | Micro-op releases chip select |
| lock | output | 1 | Keep this requester selected |
| rx_valid | input | 1 | Shifter returns a frame |
| rx_data | input | 8 | Returned frame |
| resp_valid | output | 1 | Response frame available |
| resp_ready | input | 1 | Response consumed |
| resp_data | output | 8 | Response frame |

## Verification
A fixed set of templates is run first. It includes the opcode on with three address bytes and a long dummy stretch, every optional phase off, four bytes with no dummy, an over-range byte count with a one-cycle dummy stretch, and the opcode with no address. Together these separate phase skipping from phase ordering and show the clamp. Random templates, addresses and lane modes then follow. Back-pressure on the shifter and response ports is random, and `en` drops at random. Receive strobes arrive at random times, including outside the wait for data. This shows whether fields stay stable under stall, whether a read resumes after `en` drops, and whether stray strobes are ignored.

// File: rtl/flash_seq_pkg.sv
// Shared types for the flash read sequencer.
package flash_seq_pkg;
    // Width of opcode, address byte, pad code and data frame.
    localparam int FRAME_W = 8;

    // Lane modes carried on every micro-op.
    localparam logic [1:0] LANE_ONE  = 2'd0;
    localparam logic [1:0] LANE_TWO  = 2'd1;
    localparam logic [1:0] LANE_FOUR = 2'd2;

    // Sequencer phases, visited in declaration order with skips.
    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD, PH_ADDR, PH_PAD, PH_DATA, PH_WAIT, PH_REL, PH_RESP
    } phase_e;
endpackage

// File: rtl/flash_seq_phase.sv
// Phase walker: steps through opcode, address, dummy, receive, release and
// response phases, skipping the optional ones per the template.
// Assumes the template inputs stay steady while a read is in flight.
module flash_seq_phase
    import flash_seq_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int ABW        = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           uop_fire,
    input  logic           rx_valid,
    input  logic           resp_fire,
    input  logic           cmd_en,
    input  logic [ABW-1:0] addr_bytes,
    input  logic           pad_nonzero,
    output phase_e         phase,
    output logic [ABW-1:0] byte_idx
);
    logic [ABW-1:0] nb_eff;
    phase_e         after_cmd;
    phase_e         after_idle;
    phase_e         after_addr;

    // Next-phase choices that depend on which optional phases are enabled.
    always_comb begin
        nb_eff     = (addr_bytes > ABW'(ADDR_BYTES)) ? ABW'(ADDR_BYTES) : addr_bytes;
        after_cmd  = (nb_eff != '0) ? PH_ADDR : (pad_nonzero ? PH_PAD : PH_DATA);
        after_idle = cmd_en ? PH_CMD : after_cmd;
        after_addr = pad_nonzero ? PH_PAD : PH_DATA;
    end

    // Phase register and address byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            byte_idx <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (accept) begin
                    phase    <= after_idle;
                    byte_idx <= nb_eff - ABW'(1);
                end
                PH_CMD: if (uop_fire) begin
                    phase    <= after_cmd;
                    byte_idx <= nb_eff - ABW'(1);
                end
                PH_ADDR: if (uop_fire) begin
                    if (byte_idx == '0) phase <= after_addr;
                    else                byte_idx <= byte_idx - ABW'(1);
                end
                PH_PAD:  if (uop_fire)  phase <= PH_DATA;
                PH_DATA: if (uop_fire)  phase <= PH_WAIT;
                PH_WAIT: if (rx_valid)  phase <= PH_REL;
                PH_REL:  if (uop_fire)  phase <= PH_RESP;
                PH_RESP: if (resp_fire) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R6: without a returned frame the walker keeps waiting.
    p_wait_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT && !rx_valid) |=> (phase == PH_WAIT));

    // R4: the byte index never points past the clamped address width.
    p_addr_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ADDR) |-> (byte_idx < ABW'(ADDR_BYTES)));
endmodule

// File: rtl/flash_seq_uop.sv
// Micro-op former: maps the current phase and template onto the fields
// of the micro-op offered to the shifter. Purely combinational.
module flash_seq_uop
    import flash_seq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int ABW   = 3,
    parameter int CNT_W = 8
) (
    input  phase_e               phase,
    input  logic [ABW-1:0]       byte_idx,
    input  logic [AW-1:0]        addr_q,
    input  logic [FRAME_W-1:0]   cmd_code,
    input  logic [1:0]           cmd_proto,
    input  logic [1:0]           addr_proto,
    input  logic [FRAME_W-1:0]   pad_code,
    input  logic [CNT_W-1:0]     pad_cycles,
    input  logic [1:0]           data_proto,
    output logic                 issue,
    output logic [FRAME_W-1:0]   uop_data,
    output logic [CNT_W-1:0]     uop_cnt,
    output logic [1:0]           uop_proto,
    output logic                 uop_rx,
    output logic                 uop_release
);
    logic [AW-1:0] addr_shift;

    // Bring the addressed byte down to the bottom of the word.
    assign addr_shift = addr_q >> {byte_idx, 3'b000};

    // Field selection per phase; idle phases offer nothing.
    always_comb begin
        issue       = 1'b1;
        uop_data    = '0;
        uop_cnt     = CNT_W'(FRAME_W);
        uop_proto   = LANE_ONE;
        uop_rx      = 1'b0;
        uop_release = 1'b0;
        case (phase)
            PH_CMD: begin
                uop_data  = cmd_code;
                uop_proto = cmd_proto;
            end
            PH_ADDR: begin
                uop_data  = addr_shift[FRAME_W-1:0];
                uop_proto = addr_proto;
            end
            PH_PAD: begin
                uop_data  = pad_code;
                uop_cnt   = pad_cycles;
                uop_proto = addr_proto;
            end
            PH_DATA: begin
                uop_rx    = 1'b1;
                uop_proto = data_proto;
            end
            PH_REL: begin
                uop_release = 1'b1;
                uop_cnt     = '0;
            end
            default: begin
                issue   = 1'b0;
                uop_cnt = '0;
            end
        endcase
    end
endmodule

// File: rtl/flash_seq_resp.sv
// Response holder: captures the returned frame and keeps it steady for
// the response port. Assumes capture is only pulsed while waiting for data.
module flash_seq_resp
    import flash_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [FRAME_W-1:0] din,
    input  logic               resp_valid,
    input  logic               resp_ready,
    output logic [FRAME_W-1:0] dout
);
    // Frame register, loaded once per read.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= '0;
        else if (capture) dout <= din;
    end

    // R9: an unconsumed response stays offered with unchanged data.
    p_resp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(dout)));
endmodule

// File: rtl/flash_read_seq.sv
// Flash read sequencer top: accepts a read address, issues opcode, address,
// dummy, receive and release micro-ops, returns the frame, and holds a lock
// for the arbiter. Assumes the template is steady during a read.
module flash_read_seq
    import flash_seq_pkg::*;
#(
    parameter  int ADDR_BYTES = 4,
    parameter  int CNT_W      = 8,
    localparam int AW         = FRAME_W * ADDR_BYTES,
    localparam int ABW        = $clog2(ADDR_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               cmd_en,
    input  logic [7:0]         cmd_code,
    input  logic [1:0]         cmd_proto,
    input  logic [ABW-1:0]     addr_bytes,
    input  logic [1:0]         addr_proto,
    input  logic [7:0]         pad_code,
    input  logic [CNT_W-1:0]   pad_cycles,
    input  logic [1:0]         data_proto,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [AW-1:0]      req_addr,
    output logic               uop_valid,
    input  logic               uop_ready,
    output logic [7:0]         uop_data,
    output logic [CNT_W-1:0]   uop_cnt,
    output logic [1:0]         uop_proto,
    output logic               uop_rx,
    output logic               uop_release,
    output logic               lock,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic               resp_valid,
    input  logic               resp_ready,
    output logic [7:0]         resp_data
);
    phase_e         phase;
    logic [ABW-1:0] byte_idx;
    logic [AW-1:0]  addr_q;
    logic           issue;
    logic           accept;
    logic           uop_fire;
    logic           resp_fire;
    logic           capture;

    // Handshake and status decode.
    always_comb begin
        req_ready  = en && (phase == PH_IDLE);
        accept     = req_valid && req_ready;
        uop_valid  = en && issue;
        uop_fire   = uop_valid && uop_ready;
        resp_valid = (phase == PH_RESP);
        resp_fire  = resp_valid && resp_ready;
        capture    = (phase == PH_WAIT) && rx_valid;
        lock       = (phase != PH_IDLE) && (phase != PH_RESP);
    end

    // Address latched at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= req_addr;
    end

    flash_seq_phase #(.ADDR_BYTES(ADDR_BYTES), .ABW(ABW)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .uop_fire   (uop_fire),
        .rx_valid   (rx_valid),
        .resp_fire  (resp_fire),
        .cmd_en     (cmd_en),
        .addr_bytes (addr_bytes),
        .pad_nonzero(pad_cycles != '0),
        .phase      (phase),
        .byte_idx   (byte_idx)
    );

    flash_seq_uop #(.AW(AW), .ABW(ABW), .CNT_W(CNT_W)) u_uop (
        .phase      (phase),
        .byte_idx   (byte_idx),
        .addr_q     (addr_q),
        .cmd_code   (cmd_code),
        .cmd_proto  (cmd_proto),
        .addr_proto (addr_proto),
        .pad_code   (pad_code),
        .pad_cycles (pad_cycles),
        .data_proto (data_proto),
        .issue      (issue),
        .uop_data   (uop_data),
        .uop_cnt    (uop_cnt),
        .uop_proto  (uop_proto),
        .uop_rx     (uop_rx),
        .uop_release(uop_release)
    );

    flash_seq_resp u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .din       (rx_data),
        .resp_valid(resp_valid),
        .resp_ready(resp_ready),
        .dout      (resp_data)
    );

    // R10: nothing is offered or taken while disabled.
    p_quiet_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!uop_valid && !req_ready));

    // R3: a stalled micro-op keeps its fields.
    p_uop_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=>
            $stable({uop_data, uop_cnt, uop_proto, uop_rx, uop_release}));

    // R8: acceptance raises the lock in the next cycle.
    p_lock_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> lock);

    // R8: the release handshake drops the lock.
    p_lock_off_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_fire && uop_release) |=> !lock);

    // R2: only one request per read.
    p_one_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
endmodule

// File: tb/sim_flash_read_seq.sv
`timescale 1ns/1ps
// Bench: behavioural queue model of the micro-op stream, compared each clock.
module sim_flash_read_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en, cmd_en;
    logic [7:0]  cmd_code, pad_code, pad_cycles, uop_data, uop_cnt, rx_data, resp_data;
    logic [1:0]  cmd_proto, addr_proto, data_proto, uop_proto;
    logic [2:0]  addr_bytes;
    logic        req_valid, req_ready, uop_valid, uop_ready, uop_rx, uop_release;
    logic        lock, rx_valid, resp_valid, resp_ready;
    logic [31:0] req_addr;

    always #4 clk = ~clk;

    flash_read_seq u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cmd_en(cmd_en), .cmd_code(cmd_code),
        .cmd_proto(cmd_proto), .addr_bytes(addr_bytes), .addr_proto(addr_proto),
        .pad_code(pad_code), .pad_cycles(pad_cycles), .data_proto(data_proto),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_data(uop_data),
        .uop_cnt(uop_cnt), .uop_proto(uop_proto), .uop_rx(uop_rx),
        .uop_release(uop_release), .lock(lock), .rx_valid(rx_valid),
        .rx_data(rx_data), .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_data(resp_data)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    logic [19:0] q[$];
    string       qt[$];
    int          m_state = 0;
    logic [7:0]  m_rx = 8'h00;
    int          tcount = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Item layout: {release, rx, proto, cnt, data}.
    task automatic push_item(input logic rel, input logic rx, input logic [1:0] pr,
                             input logic [7:0] cn, input logic [7:0] dt, input string tag);
        q.push_back({rel, rx, pr, cn, dt});
        qt.push_back(tag);
    endtask

    task automatic build_read();
        int nb;
        nb = (addr_bytes > 3'd4) ? 4 : int'(addr_bytes);
        if (cmd_en) push_item(1'b0, 1'b0, cmd_proto, 8'd8, cmd_code, "R3");
        for (int k = nb - 1; k >= 0; k--)
            push_item(1'b0, 1'b0, addr_proto, 8'd8, 8'((req_addr >> (8 * k)) & 32'hFF), "R4");
        if (pad_cycles != 8'd0) push_item(1'b0, 1'b0, addr_proto, pad_cycles, pad_code, "R5");
        push_item(1'b0, 1'b1, data_proto, 8'd8, 8'd0, "R6");
        push_item(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, "R7");
    endtask

    task automatic pick_template(input int idx);
        cmd_code   = 8'($urandom);
        pad_code   = 8'($urandom);
        cmd_proto  = 2'($urandom % 3);
        addr_proto = 2'($urandom % 3);
        data_proto = 2'($urandom % 3);
        case (idx)
            0: begin cmd_en = 1; addr_bytes = 3; pad_cycles = 8'd200; end
            1: begin cmd_en = 0; addr_bytes = 0; pad_cycles = 8'd0;   end
            2: begin cmd_en = 1; addr_bytes = 4; pad_cycles = 8'd0;   end
            3: begin cmd_en = 0; addr_bytes = 7; pad_cycles = 8'd1;   end // R4 clamp
            4: begin cmd_en = 1; addr_bytes = 0; pad_cycles = 8'd4;   end
            5: begin cmd_en = 0; addr_bytes = 5; pad_cycles = 8'd255; end // R4 clamp
            default: begin
                cmd_en     = 1'($urandom);
                addr_bytes = 3'($urandom);
                pad_cycles = ($urandom % 3 == 0) ? 8'd0 : 8'($urandom);
            end
        endcase
    endtask

    initial begin
        int   cyc;
        logic exp_rr, exp_uv, exp_lock, exp_rv;
        rst_n = 0; en = 1; req_valid = 0; req_addr = 0; uop_ready = 0;
        rx_valid = 0; rx_data = 0; resp_ready = 0;
        pick_template(0);
        // R1: outputs quiet during reset.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!uop_valid && !lock && !resp_valid, "R1 reset outputs",
                  {uop_valid, lock, resp_valid}, 0);
        end
        rst_n = 1;
        @(negedge clk);
        check(!uop_valid && !lock && !resp_valid, "R1 after reset",
              {uop_valid, lock, resp_valid}, 0);
        cyc = 0;
        while (tcount < 400 && cyc < 150000) begin
            cyc++;
            if (m_state == 0) pick_template(tcount);
            en         = (($urandom % 8) != 0);
            req_valid  = 1'($urandom);
            req_addr   = $urandom;
            uop_ready  = (($urandom % 3) != 0);
            rx_valid   = (($urandom % 4) == 0);   // R6: also strobed outside the wait
            rx_data    = 8'($urandom);
            resp_ready = 1'($urandom);
            #1;
            exp_rr   = en && (m_state == 0);
            exp_uv   = en && (m_state == 1);
            exp_lock = (m_state == 1) || (m_state == 2);
            exp_rv   = (m_state == 3);
            check(req_ready == exp_rr, en ? "R2 req_ready" : "R10 req_ready", req_ready, exp_rr);
            check(uop_valid == exp_uv, en ? "R6 uop_valid" : "R10 uop_valid", uop_valid, exp_uv);
            check(lock == exp_lock, "R8 lock", lock, exp_lock);
            check(resp_valid == exp_rv, "R9 resp_valid", resp_valid, exp_rv);
            if (exp_rv) check(resp_data == m_rx, "R9 resp_data", resp_data, m_rx);
            if (exp_uv && uop_valid)
                check({uop_release, uop_rx, uop_proto, uop_cnt, uop_data} == q[0],
                      {qt[0], " micro-op"},
                      {12'd0, uop_release, uop_rx, uop_proto, uop_cnt, uop_data}, {12'd0, q[0]});
            // Model step for the coming edge.
            if (m_state == 0) begin
                if (exp_rr && req_valid) begin
                    build_read();
                    m_state = 1;
                end
            end else if (m_state == 1) begin
                if (exp_uv && uop_ready) begin
                    logic [19:0] it;
                    it = q.pop_front();
                    void'(qt.pop_front());
                    if (it[18])      m_state = 2;
                    else if (it[19]) m_state = 3;
                end
            end else if (m_state == 2) begin
                if (rx_valid) begin
                    m_rx = rx_data;
                    m_state = 1;
                end
            end else if (resp_ready) begin
                m_state = 0;
                tcount++;
            end
            @(posedge clk);
            @(negedge clk);
            #0;
        end
        if (tcount < 400) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog reads=%0d expected=400", tcount);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule